// File: doc/BRIEF.md
# Raster CRT timing controller

The controller runs on the character clock and turns a small indexed set of timing registers into the raster of a cathode-ray display. A horizontal counter steps once per character and a vertical counter once per line. From their values the block decodes display enable, a combined blank signal and the horizontal and vertical sync pulses. It also keeps the linear memory address of the first character on the current line. A downstream fetch unit uses that address, while pixel serialisation, memory access and the cursor stay outside the block.

Software programs the block through one index/data write port. The horizontal registers are eight bits wide and count characters. Vertical values are ten bits wide, with their upper two bits spread over an overflow register and the maximum-scan register. The end of each blank or sync pulse is set by a truncated value: five bits horizontally, four bits for vertical sync and eight bits for vertical blank. A pulse therefore stops at the first later position whose low bits match. A lock bit guards the lowest eight registers against writes. Every output comes from a single register stage, so the counters, enables and syncs all describe the same character.

Top module: `crtc_timing`

## Requirements
- R1: Let T be register 0x00. `hcount_o` steps by one each cycle from 0 to T+4 and then returns to 0. This gives T+5 characters per line. `vcount_o` changes only when `hcount_o` returns to 0.
- R2: Let V be the ten-bit vertical total. Its bits 7:0 come from register 0x06, bit 8 from register 0x07 bit 0 and bit 9 from register 0x07 bit 5. `vcount_o` runs from 0 to V+1 and then returns to 0 on the next line wrap.
- R3: `de_o` is high exactly when `hcount_o` <= register 0x01 and `vcount_o` <= the ten-bit vertical display end. That end value takes bits 7:0 from register 0x12, bit 8 from 0x07 bit 1 and bit 9 from 0x07 bit 6.
- R4: Horizontal blank starts at character (register 0x02)+1. It stops at the first later character whose low 5 bits equal register 0x03 bits 4:0. Vertical blank starts at line B+1 and stops at the first later line whose low 8 bits equal register 0x16. B takes bits 7:0 from 0x15, bit 8 from 0x07 bit 3 and bit 9 from 0x09 bit 5. `blank_o` is the OR of the horizontal and vertical blank.
- R5: Horizontal sync is active from the character equal to register 0x04 up to, but not including, the first later character whose low 5 bits equal register 0x05 bits 4:0.
- R6: Vertical sync is active from line S up to, but not including, the first later line whose low 4 bits equal register 0x11 bits 3:0. S takes bits 7:0 from 0x10, bit 8 from 0x07 bit 2 and bit 9 from 0x07 bit 7.
- R7: A sync start at its maximum value with a sync end of zero produces no pulse. For horizontal sync these are 0x04 = 0xFF and 0x05 = 0, on a line of fewer than 256 characters. For vertical sync they are S = 0x3FF and 0x11 bits 3:0 = 0.
- R8: `hsync_o` and `vsync_o` are active high when their polarity input is 1 and active low when it is 0.
- R9: While register 0x11 bit 7 is set, writes to indices 0x00 to 0x07 are ignored. Clearing that bit allows those writes again.
- R10: The start address {0x0C, 0x0D} is copied into the line address only at the end of the vertical total. A new start address written mid-frame therefore first appears on line 0 of the next frame.
- R11: On each new line the line address advances by twice the value of register 0x13, modulo 2^16. `fetch_addr_o` is constant within a line.
- R12: When register 0x09 bit 7 is set, the line address advances only on lines with an even number. Each address is then shown on two consecutive lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 5 | Register index |
| wr_data_i | input | 8 | Register write data |
| hsync_pol_i | input | 1 | 1 = horizontal sync active high |
| vsync_pol_i | input | 1 | 1 = vertical sync active high |
| hcount_o | output | HCNT_W | Character position in the line |
| vcount_o | output | VCNT_W | Line position in the frame |
| de_o | output | 1 | Display enable |
| blank_o | output | 1 | Horizontal or vertical blank |
| hsync_o | output | 1 | Horizontal sync at the chosen polarity |
| vsync_o | output | 1 | Vertical sync at the chosen polarity |
| fetch_addr_o | output | ADDR_W | Memory address of the first character on the line |

## Verification
The bench builds the block with its default widths: a 9-bit character counter, a 10-bit line counter and a 16-bit address. It then programs short lines of 20 or 22 characters. With lines that short, a 12-line frame can be swept cycle by cycle, and so can a 771-line frame that needs both overflow bits. Each sample is compared with windows computed arithmetically from the programmed values. The long frame also places sync and blank above line 255 and turns on double scan. Its start address is close to the top of the address space, so the address wraps.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int IDX_W = 5;
  localparam int LOCK_SPAN = 8;

  localparam logic [IDX_W-1:0] IDX_HTOT   = 5'h00;
  localparam logic [IDX_W-1:0] IDX_HDE    = 5'h01;
  localparam logic [IDX_W-1:0] IDX_HBS    = 5'h02;
  localparam logic [IDX_W-1:0] IDX_HBE    = 5'h03;
  localparam logic [IDX_W-1:0] IDX_HSS    = 5'h04;
  localparam logic [IDX_W-1:0] IDX_HSE    = 5'h05;
  localparam logic [IDX_W-1:0] IDX_VTOT   = 5'h06;
  localparam logic [IDX_W-1:0] IDX_OVF    = 5'h07;
  localparam logic [IDX_W-1:0] IDX_SCAN   = 5'h09;
  localparam logic [IDX_W-1:0] IDX_STA_HI = 5'h0C;
  localparam logic [IDX_W-1:0] IDX_STA_LO = 5'h0D;
  localparam logic [IDX_W-1:0] IDX_VSS    = 5'h10;
  localparam logic [IDX_W-1:0] IDX_VSE    = 5'h11;
  localparam logic [IDX_W-1:0] IDX_VDE    = 5'h12;
  localparam logic [IDX_W-1:0] IDX_PITCH  = 5'h13;
  localparam logic [IDX_W-1:0] IDX_VBS    = 5'h15;
  localparam logic [IDX_W-1:0] IDX_VBE    = 5'h16;

  typedef struct packed {
    logic [7:0]  htot;
    logic [7:0]  hde;
    logic [7:0]  hbs;
    logic [4:0]  hbe;
    logic [7:0]  hss;
    logic [4:0]  hse;
    logic [9:0]  vtot;
    logic [9:0]  vde;
    logic [9:0]  vbs;
    logic [7:0]  vbe;
    logic [9:0]  vss;
    logic [3:0]  vse;
    logic        dbl;
    logic [15:0] start;
    logic [7:0]  pitch;
  } crtc_cfg_t;
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  output crtc_cfg_t        cfg_o
);
  crtc_cfg_t cfg_q;
  logic      lock_q;
  logic      blocked;

  assign blocked = lock_q && (wr_idx_i < IDX_W'(LOCK_SPAN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      lock_q <= 1'b0;
    end else if (wr_en_i && !blocked) begin
      case (wr_idx_i)
        IDX_HTOT:   cfg_q.htot <= wr_data_i;
        IDX_HDE:    cfg_q.hde  <= wr_data_i;
        IDX_HBS:    cfg_q.hbs  <= wr_data_i;
        IDX_HBE:    cfg_q.hbe  <= wr_data_i[4:0];
        IDX_HSS:    cfg_q.hss  <= wr_data_i;
        IDX_HSE:    cfg_q.hse  <= wr_data_i[4:0];
        IDX_VTOT:   cfg_q.vtot[7:0] <= wr_data_i;
        IDX_OVF: begin
          // high bits of the vertical values, spread over one register
          cfg_q.vtot[8] <= wr_data_i[0];
          cfg_q.vde[8]  <= wr_data_i[1];
          cfg_q.vss[8]  <= wr_data_i[2];
          cfg_q.vbs[8]  <= wr_data_i[3];
          cfg_q.vtot[9] <= wr_data_i[5];
          cfg_q.vde[9]  <= wr_data_i[6];
          cfg_q.vss[9]  <= wr_data_i[7];
        end
        IDX_SCAN: begin
          cfg_q.dbl    <= wr_data_i[7];
          cfg_q.vbs[9] <= wr_data_i[5];
        end
        IDX_STA_HI: cfg_q.start[15:8] <= wr_data_i;
        IDX_STA_LO: cfg_q.start[7:0]  <= wr_data_i;
        IDX_VSS:    cfg_q.vss[7:0] <= wr_data_i;
        IDX_VSE: begin
          cfg_q.vse <= wr_data_i[3:0];
          lock_q    <= wr_data_i[7];
        end
        IDX_VDE:    cfg_q.vde[7:0] <= wr_data_i;
        IDX_PITCH:  cfg_q.pitch <= wr_data_i;
        IDX_VBS:    cfg_q.vbs[7:0] <= wr_data_i;
        IDX_VBE:    cfg_q.vbe <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/crtc_span.sv
module crtc_span #(
  parameter int POS_W = 10,
  parameter int END_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] start_i,
  input  logic [END_W-1:0] end_i,
  output logic             act_o
);
  logic act_q;

  // start is a full compare, end only looks at the low END_W bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    act_q <= 1'b0;
    else if (adv_i) act_q <= act_q ? (pos_i[END_W-1:0] != end_i) : (pos_i == start_i);
  end

  assign act_o = act_q;
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
#(
  parameter int HCNT_W = 9,
  parameter int VCNT_W = 10,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [7:0]        wr_data_i,
  input  logic              hsync_pol_i,
  input  logic              vsync_pol_i,
  output logic [HCNT_W-1:0] hcount_o,
  output logic [VCNT_W-1:0] vcount_o,
  output logic              de_o,
  output logic              blank_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [ADDR_W-1:0] fetch_addr_o
);
  localparam int HPOS_W = HCNT_W + 1;
  localparam int VPOS_W = VCNT_W + 1;

  crtc_cfg_t cfg;

  crtc_regfile u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_data_i(wr_data_i),
    .cfg_o    (cfg)
  );

  logic [HCNT_W-1:0] h_q, h_next, h_last;
  logic [VCNT_W-1:0] v_q, v_next, v_last;
  logic [ADDR_W-1:0] line_addr_q;
  logic              h_wrap, v_wrap;

  assign h_last = HCNT_W'(cfg.htot) + HCNT_W'(4);
  assign v_last = VCNT_W'(cfg.vtot) + VCNT_W'(1);
  assign h_wrap = (h_q == h_last);
  assign v_wrap = h_wrap && (v_q == v_last);
  assign h_next = h_wrap ? '0 : h_q + HCNT_W'(1);
  assign v_next = v_wrap ? '0 : (h_wrap ? v_q + VCNT_W'(1) : v_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q         <= '0;
      v_q         <= '0;
      line_addr_q <= '0;
    end else begin
      h_q <= h_next;
      v_q <= v_next;
      if (v_wrap)
        line_addr_q <= ADDR_W'(cfg.start);
      else if (h_wrap && (!cfg.dbl || !v_next[0]))
        line_addr_q <= line_addr_q + ADDR_W'({cfg.pitch, 1'b0});
    end
  end

  // window flags, each aligned with the current counter value
  logic hb_act, hs_act, vb_act, vs_act;

  crtc_span #(.POS_W(HPOS_W), .END_W(5)) u_hblank (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(1'b1),
    .pos_i({1'b0, h_next}), .start_i(HPOS_W'(cfg.hbs) + HPOS_W'(1)),
    .end_i(cfg.hbe), .act_o(hb_act)
  );

  crtc_span #(.POS_W(HPOS_W), .END_W(5)) u_hsync (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(1'b1),
    .pos_i({1'b0, h_next}), .start_i(HPOS_W'(cfg.hss)),
    .end_i(cfg.hse), .act_o(hs_act)
  );

  crtc_span #(.POS_W(VPOS_W), .END_W(8)) u_vblank (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(h_wrap),
    .pos_i({1'b0, v_next}), .start_i(VPOS_W'(cfg.vbs) + VPOS_W'(1)),
    .end_i(cfg.vbe), .act_o(vb_act)
  );

  crtc_span #(.POS_W(VPOS_W), .END_W(4)) u_vsync (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(h_wrap),
    .pos_i({1'b0, v_next}), .start_i(VPOS_W'(cfg.vss)),
    .end_i(cfg.vse), .act_o(vs_act)
  );

  logic de_d;
  assign de_d = (h_q <= HCNT_W'(cfg.hde)) && (v_q <= VCNT_W'(cfg.vde));

  logic hs_q, vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcount_o     <= '0;
      vcount_o     <= '0;
      de_o         <= 1'b0;
      blank_o      <= 1'b0;
      hs_q         <= 1'b0;
      vs_q         <= 1'b0;
      fetch_addr_o <= '0;
    end else begin
      hcount_o     <= h_q;
      vcount_o     <= v_q;
      de_o         <= de_d;
      blank_o      <= hb_act || vb_act;
      hs_q         <= hs_act;
      vs_q         <= vs_act;
      fetch_addr_o <= line_addr_q;
    end
  end

  assign hsync_o = hs_q ~^ hsync_pol_i;
  assign vsync_o = vs_q ~^ vsync_pol_i;
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk #(
  parameter int HCNT_W = 9,
  parameter int VCNT_W = 10,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [4:0]        wr_idx_i,
  input logic              lock_i,
  input logic [7:0]        htot_i,
  input logic [15:0]       start_i,
  input logic [HCNT_W-1:0] hcount_o,
  input logic [VCNT_W-1:0] vcount_o,
  input logic [ADDR_W-1:0] fetch_addr_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_hcount_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && hcount_o != '0) |-> hcount_o == $past(hcount_o) + HCNT_W'(1));

  assert_vcount_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && hcount_o != '0) |-> $stable(vcount_o));

  assert_lock_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == 5'h00 && lock_i) |=> $stable(htot_i));

  assert_start_reload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && hcount_o == '0 && vcount_o == '0 && $past(vcount_o) != '0)
      |-> fetch_addr_o == ADDR_W'($past(start_i, 2)));

  assert_addr_per_line_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && hcount_o != '0) |-> $stable(fetch_addr_o));
endmodule

bind crtc_timing crtc_timing_chk #(
  .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .lock_i      (u_regs.lock_q),
  .htot_i      (cfg.htot),
  .start_i     (cfg.start),
  .hcount_o    (hcount_o),
  .vcount_o    (vcount_o),
  .fetch_addr_o(fetch_addr_o)
);

// File: tb/crtc_timing_test.sv
module crtc_timing_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic       hpol = 1'b1;
  logic       vpol = 1'b1;
  logic [8:0]  hcount;
  logic [9:0]  vcount;
  logic        de, blank, hsync, vsync;
  logic [15:0] fetch;

  always #5 clk = ~clk;

  crtc_timing uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .hsync_pol_i(hpol), .vsync_pol_i(vpol),
    .hcount_o(hcount), .vcount_o(vcount), .de_o(de), .blank_o(blank),
    .hsync_o(hsync), .vsync_o(vsync), .fetch_addr_o(fetch)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int c_htot, c_hde, c_hbs, c_hbe, c_hss, c_hse;
  int c_vtot, c_vde, c_vbs, c_vbe, c_vss, c_vse, c_dbl, c_start, c_off;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at h=%0d v=%0d",
               req, act, act, exp, exp, hcount, vcount);
    end
  endtask

  task automatic wr(int idx, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic bit in_win(int x, int s, int e, int bits);
    int m = 1 << bits;
    int d = ((e - (s % m) - 1) % m + m) % m;
    return (x >= s) && (x < s + d + 1);
  endfunction

  function automatic int frame_len();
    return (c_htot + 5) * (c_vtot + 2);
  endfunction

  function automatic int exp_addr(int v);
    return (c_start + 2 * c_off * (c_dbl != 0 ? v / 2 : v)) & 16'hFFFF;
  endfunction

  task automatic program_all();
    int ovf, scan;
    ovf  = ((c_vtot >> 8) & 1) | (((c_vde >> 8) & 1) << 1) | (((c_vss >> 8) & 1) << 2) |
           (((c_vbs >> 8) & 1) << 3) | (((c_vtot >> 9) & 1) << 5) |
           (((c_vde >> 9) & 1) << 6) | (((c_vss >> 9) & 1) << 7);
    scan = (c_dbl << 7) | (((c_vbs >> 9) & 1) << 5);
    wr(5'h11, c_vse);
    wr(5'h00, c_htot); wr(5'h01, c_hde); wr(5'h02, c_hbs); wr(5'h03, c_hbe);
    wr(5'h04, c_hss);  wr(5'h05, c_hse); wr(5'h06, c_vtot & 8'hFF); wr(5'h07, ovf);
    wr(5'h09, scan);   wr(5'h0C, c_start >> 8); wr(5'h0D, c_start & 8'hFF);
    wr(5'h10, c_vss & 8'hFF); wr(5'h12, c_vde & 8'hFF); wr(5'h13, c_off);
    wr(5'h15, c_vbs & 8'hFF); wr(5'h16, c_vbe);
  endtask

  task automatic config_a();
    c_htot = 15; c_hde = 11; c_hbs = 11; c_hbe = 19; c_hss = 14; c_hse = 17;
    c_vtot = 10; c_vde = 7;  c_vbs = 7;  c_vbe = 11; c_vss = 9;  c_vse = 10;
    c_dbl = 0; c_start = 16'h1234; c_off = 5;
  endtask

  // cycle-by-cycle sweep; sync tag names the requirement under test
  task automatic sweep(int ncyc, string stag, output int vmax, output int hs_seen, output int vs_seen);
    int ph = 0, pv = 0;
    bit have = 0;
    vmax = 0; hs_seen = 0; vs_seen = 0;
    for (int i = 0; i < ncyc; i++) begin
      int h, v, eh, ev;
      bit hs_a, vs_a, bl;
      @(negedge clk);
      h = int'(hcount); v = int'(vcount);
      if (have) begin
        eh = (ph == c_htot + 4) ? 0 : ph + 1;
        ev = (ph == c_htot + 4) ? ((pv == c_vtot + 1) ? 0 : pv + 1) : pv;
        chk(h == eh, "R1 hcount", h, eh);
        chk(v == ev, "R2 vcount", v, ev);
      end
      have = 1; ph = h; pv = v;
      if (v > vmax) vmax = v;
      chk(de == ((h <= c_hde) && (v <= c_vde)), "R3 de", int'(de), int'((h <= c_hde) && (v <= c_vde)));
      bl = in_win(h, c_hbs + 1, c_hbe, 5) || in_win(v, c_vbs + 1, c_vbe, 8);
      chk(blank == bl, "R4 blank", int'(blank), int'(bl));
      hs_a = in_win(h, c_hss, c_hse, 5);
      vs_a = in_win(v, c_vss, c_vse, 4);
      chk(hsync == (hs_a ~^ hpol), {stag, " hsync"}, int'(hsync), int'(hs_a ~^ hpol));
      chk(vsync == (vs_a ~^ vpol), {stag, " vsync"}, int'(vsync), int'(vs_a ~^ vpol));
      if (hsync == hpol) hs_seen++;
      if (vsync == vpol) vs_seen++;
      chk(int'(fetch) == exp_addr(v), c_dbl != 0 ? "R12 fetch" : "R11 fetch", int'(fetch), exp_addr(v));
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int vmax, hs_n, vs_n;
    // reset state
    repeat (3) @(negedge clk);
    chk(hcount == 0, "R1 reset hcount", int'(hcount), 0);
    chk(vcount == 0, "R2 reset vcount", int'(vcount), 0);
    chk(de == 0 && blank == 0, "R3 reset de/blank", int'({de, blank}), 0);
    chk(hsync == 0 && vsync == 0, "R8 reset syncs", int'({hsync, vsync}), 0);
    chk(fetch == 0, "R10 reset fetch", int'(fetch), 0);
    rst_n = 1'b1;

    // small frame, active-high syncs
    config_a();
    program_all();
    repeat (3 * frame_len()) @(posedge clk);
    sweep(2 * frame_len(), "R5/R6", vmax, hs_n, vs_n);
    chk(vmax == c_vtot + 1, "R2 last line", vmax, c_vtot + 1);

    // active-low syncs
    hpol = 1'b0; vpol = 1'b0;
    sweep(frame_len(), "R8", vmax, hs_n, vs_n);
    hpol = 1'b1; vpol = 1'b1;

    // suppressed sync pulses
    c_hss = 255; c_hse = 0; c_vss = 10'h3FF; c_vse = 0;
    program_all();
    repeat (3 * frame_len()) @(posedge clk);
    sweep(2 * frame_len(), "R7", vmax, hs_n, vs_n);
    chk(hs_n == 0, "R7 no hsync pulse", hs_n, 0);
    chk(vs_n == 0, "R7 no vsync pulse", vs_n, 0);

    // write lock on the low registers
    config_a();
    program_all();
    wr(5'h11, 8'h80 | c_vse);
    wr(5'h00, 30);
    wr(5'h06, 40);
    repeat (3 * frame_len()) @(posedge clk);
    sweep(2 * frame_len(), "R9", vmax, hs_n, vs_n);
    wr(5'h11, c_vse);
    c_htot = 17;
    wr(5'h00, c_htot);
    repeat (3 * frame_len()) @(posedge clk);
    sweep(frame_len(), "R9", vmax, hs_n, vs_n);

    // start address written mid-frame
    config_a();
    program_all();
    repeat (3 * frame_len()) @(posedge clk);
    @(negedge clk);
    while (!(vcount == 3 && hcount == 0)) @(negedge clk);
    wr(5'h0C, 8'h40);
    wr(5'h0D, 8'h00);
    while (vcount != 5) @(negedge clk);
    chk(int'(fetch) == 16'h1234 + 50, "R10 old start this frame", int'(fetch), 16'h1234 + 50);
    while (vcount != 0) @(negedge clk);
    chk(int'(fetch) == 16'h4000, "R10 new start line 0", int'(fetch), 16'h4000);
    while (vcount != 5) @(negedge clk);
    chk(int'(fetch) == 16'h4000 + 50, "R10 new start next frame", int'(fetch), 16'h4000 + 50);
    c_start = 16'h4000;

    // tall frame: overflow bits, double scan, address wrap
    c_vtot = 10'h301; c_vde = 10'h1F0; c_vbs = 10'h2F0; c_vbe = 8'h00;
    c_vss = 10'h205; c_vse = 7; c_dbl = 1; c_start = 16'hFFF0; c_off = 8'h40;
    program_all();
    repeat (2 * frame_len()) @(posedge clk);
    sweep(frame_len() + 40, "R6", vmax, hs_n, vs_n);
    chk(vmax == c_vtot + 1, "R2 tall last line", vmax, c_vtot + 1);
    chk(vs_n == 2 * (c_htot + 5), "R6 tall vsync length", vs_n, 2 * (c_htot + 5));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule